// File: doc/BRIEF.md
# Nine-bit multiprocessor UART

This block is a full-duplex asynchronous serial port whose frames carry eight data bits and a ninth bit that software chooses. A frame is eleven bit times long: a low start bit, the eight data bits least-significant first, the ninth bit, and a high stop bit. The bit rate is a fixed fraction of the system clock. One control input selects a bit time of either 64 or 32 clocks.

Software starts a transmission by pulsing a write strobe with a byte. The ninth bit is taken from a control input at that moment. A done flag rises when the stop bit begins. The receiver runs only while it is enabled. It oversamples the line sixteen times per bit, rejects false start edges, and decides each bit by a three-sample majority vote.

In multiprocessor mode, a received frame is kept only if it is an address frame: the ninth bit must be 1 and the byte must match the unit's own address at the bit positions its mask selects. A frame is never kept while the receive-done flag is still set. Both flags are cleared by strobes. An interrupt output is active while either flag is set and interrupts are enabled.

Top module: `nine_bit_uart`

## Requirements
- R1: `txd` is 1 while idle. A transmitted frame is, in order: a start bit of 0, `tx_wdata` bit 0 up to bit 7, the ninth bit, and a stop bit of 1. Each bit lasts one bit time.
- R2: One bit time is 64 clocks when `div_sel` is 0 and 32 clocks when it is 1. The transmitter captures `div_sel` when a frame starts. The receiver uses the same bit time.
- R3: A `tx_wr` pulse while the transmitter is idle starts a frame. The start bit is driven from the clock edge that samples the strobe. `tx_bit9` is captured at that edge. A `tx_wr` pulse during a frame is ignored and does not alter the frame.
- R4: `tx_done` rises exactly 10 bit times after the write edge, which is the start of the stop bit. It stays set until it is cleared.
- R5: While `rx_en` is 0, the receiver stores nothing and `rx_done` stays as it is.
- R6: The start bit must still read 0 at mid-bit, otherwise the receiver returns to idle and stores nothing. Each bit is the majority of three samples around mid-bit, so a single disturbed sample has no effect. The value of the stop bit is ignored.
- R7: After the stop bit, the byte goes to `rx_rdata` and the ninth bit goes to `rx_bit9`, and `rx_done` is set, when `rx_done` is 0 and one of these holds: `mp_mode` is 0; or the ninth bit is 1 and `((byte ^ own_addr) & addr_mask) == 0`.
- R8: When the R7 condition fails (including when `rx_done` is already 1), `rx_rdata`, `rx_bit9` and `rx_done` keep their values.
- R9: `irq` equals `int_en & (tx_done | rx_done)`.
- R10: `clr_tx_done` and `clr_rx_done` clear their flags. If a set and a clear happen in the same cycle, the set wins.
- R11: After reset: `txd` = 1, both flags = 0, `rx_rdata` = 0, `rx_bit9` = 0, `irq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_wdata | input | 8 | Byte to transmit |
| tx_bit9 | input | 1 | Ninth bit for the next transmitted frame |
| div_sel | input | 1 | 0: bit time of 64 clocks, 1: bit time of 32 clocks |
| rx_en | input | 1 | Receive enable |
| mp_mode | input | 1 | Multiprocessor address filtering enable |
| own_addr | input | 8 | Own address of the unit |
| addr_mask | input | 8 | Address compare mask (1 = compare this bit) |
| int_en | input | 1 | Interrupt enable |
| clr_tx_done | input | 1 | Clear strobe for tx_done |
| clr_rx_done | input | 1 | Clear strobe for rx_done |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| rx_rdata | output | 8 | Receive buffer |
| rx_bit9 | output | 1 | Ninth bit of the last stored frame |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check these on every cycle:
- the line stays high while the transmitter is idle;
- the stop bit is on the line when `tx_done` rises;
- the receive buffer changes only together with a rising `rx_done`, and only if the receiver was enabled;
- a frame stored in multiprocessor mode carries a ninth bit of 1;
- the buffer holds while `rx_done` is pending.

Only the bench's scenarios can show the rest:
- bit order and bit times at both rates;
- the exact cycle when `tx_done` rises;
- the filter decision for mixed address, mask and ninth-bit patterns;
- rejection of a false start, tolerance of a glitch, and a stop bit of 0;
- that a write during a frame is ignored.

// File: rtl/nine_bit_uart.sv
module nine_bit_uart #(
  parameter int DW       = 8,
  parameter int SLOW_DIV = 64,
  parameter int FAST_DIV = 32,
  parameter int OVS      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_bit9,
  input  logic          div_sel,
  input  logic          rx_en,
  input  logic          mp_mode,
  input  logic [DW-1:0] own_addr,
  input  logic [DW-1:0] addr_mask,
  input  logic          int_en,
  input  logic          clr_tx_done,
  input  logic          clr_rx_done,
  input  logic          rxd,
  output logic          txd,
  output logic [DW-1:0] rx_rdata,
  output logic          rx_bit9,
  output logic          tx_done,
  output logic          rx_done,
  output logic          irq
);
  localparam int FRAME   = DW + 3;
  localparam int SLOW_TK = SLOW_DIV / OVS;
  localparam int FAST_TK = FAST_DIV / OVS;
  localparam int BW      = $clog2(SLOW_DIV) + 1;
  localparam int PW      = $clog2(SLOW_TK) + 1;
  localparam int IW      = $clog2(FRAME) + 1;
  localparam int SW      = $clog2(OVS);
  localparam int MID     = OVS / 2;

  // transmitter
  logic [FRAME-1:0] tx_sh;
  logic             tx_busy, tx_fast;
  logic [BW-1:0]    tx_cnt;
  logic [IW-1:0]    tx_idx;

  wire [BW-1:0] tx_last    = tx_fast ? BW'(FAST_DIV - 1) : BW'(SLOW_DIV - 1);
  wire          tx_bit_end = tx_busy && (tx_cnt == tx_last);
  wire          tx_set     = tx_bit_end && (tx_idx == IW'(FRAME - 2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '1;
      tx_busy <= 1'b0;
      tx_fast <= 1'b0;
      tx_cnt  <= '0;
      tx_idx  <= '0;
    end else if (!tx_busy) begin
      if (tx_wr) begin
        tx_sh   <= {1'b1, tx_bit9, tx_wdata, 1'b0};
        tx_busy <= 1'b1;
        tx_fast <= div_sel;
        tx_cnt  <= '0;
        tx_idx  <= '0;
      end
    end else if (tx_bit_end) begin
      tx_cnt <= '0;
      tx_sh  <= {1'b1, tx_sh[FRAME-1:1]};
      tx_idx <= tx_idx + 1'b1;
      if (tx_idx == IW'(FRAME - 1)) tx_busy <= 1'b0;
    end else begin
      tx_cnt <= tx_cnt + 1'b1;
    end
  end

  assign txd = tx_sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tx_done <= 1'b0;
    else if (tx_set)      tx_done <= 1'b1;
    else if (clr_tx_done) tx_done <= 1'b0;
  end

  // oversampling tick
  logic [PW-1:0] presc;
  wire  [PW-1:0] tk_last = div_sel ? PW'(FAST_TK - 1) : PW'(SLOW_TK - 1);
  wire           tick    = (presc >= tk_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc <= '0;
    else        presc <= tick ? '0 : presc + 1'b1;
  end

  // receiver
  logic          rx_s1, rx_s2, rx_prev, rx_act, rx_b9;
  logic [1:0]    rx_v;
  logic [SW-1:0] rx_sc;
  logic [IW-1:0] rx_idx;
  logic [DW-1:0] rx_sh;

  wire vote     = (rx_v[0] & rx_v[1]) | (rx_v[0] & rx_s2) | (rx_v[1] & rx_s2);
  wire decide   = tick && rx_en && rx_act && (rx_sc == SW'(MID + 1));
  wire stop_mid = decide && (rx_idx == IW'(FRAME - 1));
  wire addr_hit = ((rx_sh ^ own_addr) & addr_mask) == '0;
  wire accept   = stop_mid && !rx_done && (!mp_mode || (rx_b9 && addr_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_prev <= 1'b1;
      rx_act  <= 1'b0;
      rx_sc   <= '0;
      rx_idx  <= '0;
      rx_v    <= '0;
      rx_sh   <= '0;
      rx_b9   <= 1'b0;
    end else begin
      if (tick) rx_prev <= rx_s2;
      if (!rx_en) begin
        rx_act <= 1'b0;
      end else if (tick) begin
        if (!rx_act) begin
          if (rx_prev && !rx_s2) begin
            rx_act <= 1'b1;
            rx_sc  <= '0;
            rx_idx <= '0;
          end
        end else begin
          rx_sc <= rx_sc + 1'b1;
          if (rx_sc == SW'(MID - 1)) rx_v[0] <= rx_s2;
          if (rx_sc == SW'(MID))     rx_v[1] <= rx_s2;
          if (rx_sc == SW'(MID + 1)) begin
            rx_idx <= rx_idx + 1'b1;
            if (rx_idx == '0) begin
              if (vote) rx_act <= 1'b0;
            end else if (rx_idx <= IW'(DW)) begin
              rx_sh <= {vote, rx_sh[DW-1:1]};
            end else if (rx_idx == IW'(DW + 1)) begin
              rx_b9 <= vote;
            end else begin
              rx_act <= 1'b0;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rdata <= '0;
      rx_bit9  <= 1'b0;
    end else if (accept) begin
      rx_rdata <= rx_sh;
      rx_bit9  <= rx_b9;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rx_done <= 1'b0;
    else if (accept)      rx_done <= 1'b1;
    else if (clr_rx_done) rx_done <= 1'b0;
  end

  assign irq = int_en & (tx_done | rx_done);

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  // R4
  done_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (txd && tx_busy));
  // R7
  buf_moves_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_rdata) |-> $rose(rx_done));
  // R5
  store_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(rx_en));
  // R7
  mp_store_ninth_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_done) && $past(mp_mode)) |-> rx_bit9);
  // R8
  pending_holds_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_done) && !$past(clr_rx_done)) |-> ($stable(rx_rdata) && $stable(rx_bit9)));
endmodule

// File: tb/test_nine_bit_uart.sv
module test_nine_bit_uart;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       tx_wr = 0, tx_bit9 = 0, div_sel = 0, rx_en = 0, mp_mode = 0, int_en = 0;
  logic       clr_tx_done = 0, clr_rx_done = 0, rx_drv = 1, loop = 0;
  logic [7:0] tx_wdata = 0, own_addr = 0, addr_mask = 0;
  logic       txd, rx_bit9, tx_done, rx_done, irq, rxd;
  logic [7:0] rx_rdata;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_data = 0;
  logic       exp_b9 = 0, exp_done = 0;

  assign rxd = loop ? txd : rx_drv;
  always #(CLK_PERIOD/2) clk = ~clk;

  nine_bit_uart i_nine_bit_uart (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_bit9(tx_bit9),
    .div_sel(div_sel), .rx_en(rx_en), .mp_mode(mp_mode), .own_addr(own_addr),
    .addr_mask(addr_mask), .int_en(int_en), .clr_tx_done(clr_tx_done),
    .clr_rx_done(clr_rx_done), .rxd(rxd), .txd(txd), .rx_rdata(rx_rdata),
    .rx_bit9(rx_bit9), .tx_done(tx_done), .rx_done(rx_done), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic accept_f(input logic done, input logic mp, input logic b9,
                                    input logic [7:0] d, input logic [7:0] a, input logic [7:0] m);
    return !done && (!mp || (b9 && (((d ^ a) & m) == 8'h00)));
  endfunction

  function automatic logic frame_bit(input logic [7:0] d, input logic b9, input logic stp, input int i);
    if (i == 0) return 1'b0;
    if (i <= 8) return d[i-1];
    if (i == 9) return b9;
    return stp;
  endfunction

  task automatic pulse_clr(input logic which_rx);
    @(negedge clk);
    if (which_rx) clr_rx_done = 1; else clr_tx_done = 1;
    @(negedge clk);
    clr_rx_done = 0; clr_tx_done = 0;
    if (which_rx) exp_done = 0;
  endtask

  // Transmit one frame and check txd at mid-bit and the tx_done timing.
  task automatic do_tx(input logic [7:0] d, input logic b9, input logic poke, input logic hold_clr);
    int bt;
    bt = div_sel ? 32 : 64;
    pulse_clr(1'b0);
    @(negedge clk);
    tx_wdata = d; tx_bit9 = b9; tx_wr = 1;
    if (hold_clr) clr_tx_done = 1;
    @(negedge clk);
    tx_wr = 0; tx_bit9 = ~b9;
    for (int m = 0; m < 12 * bt; m++) begin
      if (m > 0) @(negedge clk);
      if (poke && m == 3 * bt) begin tx_wr = 1; tx_wdata = ~d; end
      else tx_wr = 0;
      if (m % bt == bt / 2 && m / bt < 11)
        check(poke ? "R3 write during frame ignored" : "R1/R2 txd bit", txd, frame_bit(d, b9, 1'b1, m / bt));
      if (m == 10 * bt - 1) check("R4 tx_done before stop", tx_done, 0);
      if (m == 10 * bt)     check("R4 tx_done at stop start", tx_done, 1);
      if (hold_clr && m == 10 * bt + 1) check("R10 clear after set", tx_done, 0);
      if (m == 11 * bt + 2) check("R1 idle high", txd, 1);
    end
    clr_tx_done = 0;
  endtask

  // Drive one frame on rx_drv; optional stop value and single-sample glitch in data bit 0.
  task automatic send_frame(input logic [7:0] d, input logic b9, input logic stp, input logic glitch);
    int bt;
    bt = div_sel ? 32 : 64;
    for (int i = 0; i < 11; i++)
      for (int c = 0; c < bt; c++) begin
        @(negedge clk);
        rx_drv = frame_bit(d, b9, stp, i);
        if (glitch && i == 1 && c >= bt / 2 && c < bt / 2 + bt / 16) rx_drv = ~rx_drv;
      end
    @(negedge clk);
    rx_drv = 1;
    repeat (bt) @(negedge clk);
  endtask

  task automatic expect_rx(input string req, input logic [7:0] d, input logic b9);
    if (accept_f(exp_done, mp_mode, b9, d, own_addr, addr_mask) && rx_en) begin
      exp_data = d; exp_b9 = b9; exp_done = 1;
    end
    check(req, rx_done, exp_done);
    check(req, rx_rdata, exp_data);
    check(req, rx_bit9, exp_b9);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic b9, acc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R11 txd", txd, 1);
    check("R11 tx_done", tx_done, 0);
    check("R11 rx_done", rx_done, 0);
    check("R11 rx_rdata", rx_rdata, 0);
    check("R11 irq", irq, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 R2 R4 at both rates
    div_sel = 0; do_tx(8'hA5, 1'b1, 0, 0);
    div_sel = 1; do_tx(8'h3C, 1'b0, 0, 0);
    // R9 interrupt combine
    int_en = 0; @(negedge clk); check("R9 irq masked", irq, 0);
    int_en = 1; @(negedge clk); check("R9 irq tx_done", irq, 1);
    pulse_clr(1'b0); check("R10 clr tx_done", tx_done, 0);
    check("R9 irq idle", irq, 0);
    // R3 write during frame
    div_sel = 0; do_tx(8'h96, 1'b0, 1, 0);
    // R10 set wins over clear
    do_tx(8'h01, 1'b1, 0, 1);

    // R5 receiver disabled
    rx_en = 0; send_frame(8'h55, 1'b0, 1'b1, 0);
    check("R5 disabled no store", rx_done, 0);
    check("R5 disabled buffer", rx_rdata, 0);
    rx_en = 1; repeat (8) @(negedge clk);
    // R6 false start then recovery
    @(negedge clk); rx_drv = 0; repeat (16) @(negedge clk); rx_drv = 1;
    repeat (160) @(negedge clk);
    check("R6 false start", rx_done, 0);
    send_frame(8'hC3, 1'b0, 1'b1, 0); expect_rx("R7 plain receive", 8'hC3, 1'b0);
    check("R9 irq rx_done", irq, 1);
    // R8 pending flag blocks store
    send_frame(8'h12, 1'b1, 1'b1, 0); expect_rx("R8 held while pending", 8'h12, 1'b1);
    pulse_clr(1'b1); check("R10 clr rx_done", rx_done, 0);
    // R6 stop bit 0 ignored, glitch tolerated
    send_frame(8'h6E, 1'b1, 1'b0, 0); expect_rx("R6 stop 0 accepted", 8'h6E, 1'b1);
    pulse_clr(1'b1);
    send_frame(8'h81, 1'b0, 1'b1, 1); expect_rx("R6 glitch majority", 8'h81, 1'b0);
    pulse_clr(1'b1);
    // R7 R8 multiprocessor directed
    mp_mode = 1; own_addr = 8'h5A; addr_mask = 8'hF0;
    send_frame(8'h5A, 1'b0, 1'b1, 0); expect_rx("R8 data frame in mp", 8'h5A, 1'b0);
    send_frame(8'h4A, 1'b1, 1'b1, 0); expect_rx("R8 address mismatch", 8'h4A, 1'b1);
    send_frame(8'h53, 1'b1, 1'b1, 0); expect_rx("R7 masked address match", 8'h53, 1'b1);
    pulse_clr(1'b1);

    // random loopback
    loop = 1;
    for (int n = 0; n < 36; n++) begin
      @(negedge clk);
      mp_mode = $urandom % 2; div_sel = $urandom % 2;
      own_addr = $urandom; addr_mask = $urandom;
      b9 = $urandom % 2; d = $urandom;
      if ($urandom % 2) d = own_addr ^ (8'($urandom) & ~addr_mask);
      if ($urandom % 4 != 0) pulse_clr(1'b1);
      acc = accept_f(exp_done, mp_mode, b9, d, own_addr, addr_mask);
      do_tx(d, b9, 0, 0);
      expect_rx(acc ? "R7 loopback store" : "R8 loopback reject", d, b9);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule